// File: doc/BRIEF.md
# Data-Processing Execute Stage with Condition Flags

This block is the arithmetic and logic execute stage for the sixteen register-to-register data-processing operations of a 32-bit RISC core. The decode stage hands it the first operand, a second operand that has already passed through the barrel shifter, and the shifter's carry-out. It also supplies the 4-bit operation code, the set-flags bit, the destination register index and the current N, Z, C and V flags. One clock edge later the stage presents the result together with three write strobes: one for the general register file, one for the program counter and one for a full status-word load. It also presents the flag values the core should hold next.

Comparison operations compute a full result that is used only for the flags. Logical operations take their carry from the shifter, while arithmetic operations take it from the adder. A subtraction reports carry as "no borrow". When flag setting is requested and the destination is the program counter index, the normal flag update is skipped. The top nibble of the result is loaded into the flags instead, and this also happens for comparisons.

Top module: `dp_exec_alu`

## Requirements
- R1: Logical codes give: 0 = op1 AND op2, 1 = op1 XOR op2, 12 = op1 OR op2, 13 = op2, 14 = op1 AND NOT op2, 15 = NOT op2.
- R2: Code 4 gives op1 + op2 and code 5 gives op1 + op2 + C. With set_flags high, C becomes the unsigned carry out of bit 31 and V becomes the signed overflow.
- R3: Code 2 gives op1 − op2 and code 3 gives op2 − op1. Code 6 gives op1 − op2 + C − 1 and code 7 gives op2 − op1 + C − 1. With set_flags high, C is 1 exactly when no unsigned borrow occurs and V is the signed overflow.
- R4: The compare codes produce their result for the flags only and never raise reg_we or pc_we: 8 gives AND, 9 gives XOR, 10 gives op1 − op2 and 11 gives op1 + op2. The result still appears on `result`.
- R5: For a logical or test code with set_flags high and dest_idx not 15, N is result bit 31, Z is high when the result is zero, C equals shift_carry and V keeps its incoming value.
- R6: With set_flags low, flags_out equals the incoming flags, whatever the operation.
- R7: With set_flags high and dest_idx equal to 15, status_we is high and flags_out equals result bits 31:28 ({N,Z,C,V}). This holds for the compare codes as well.
- R8: For a non-compare code with dest_idx 15, pc_we is high and reg_we is low. For a non-compare code with any other index, reg_we is high and pc_we is low.
- R9: Each operation accepted with in_valid high appears one rising edge later with out_valid high. A cycle without in_valid gives out_valid and all three strobes low on the next edge.
- R10: While rst_n is low at a rising edge, out_valid, the three strobes and flags_out are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation presented this cycle |
| opcode | input | 4 | Operation code (see R1 to R4) |
| set_flags | input | 1 | Update flags from this operation |
| dest_idx | input | 4 | Destination register index; 15 is the program counter |
| op1 | input | 32 | First operand |
| op2 | input | 32 | Shifted second operand |
| shift_carry | input | 1 | Carry-out of the barrel shifter |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| out_valid | output | 1 | Registered result is valid |
| result | output | 32 | Registered operation result |
| reg_we | output | 1 | Write result to the general register file |
| pc_we | output | 1 | Write result to the program counter |
| status_we | output | 1 | Flags were loaded from the result's top nibble |
| flags_out | output | 4 | Next flags {N,Z,C,V} |

## Verification
The result, every strobe and the next flags are all due one rising edge after the cycle in which in_valid was high, with no other latency in the block. The driver applies each operation on a falling edge and queues the value the arithmetic model predicts. The monitor wakes 1 ns after each rising edge and pops exactly one queued item whenever out_valid is high. It also flags an output that turns up with nothing queued, and a queued item that is still waiting when out_valid is low. Idle cycles mixed into the stimulus check that out_valid drops on the edge after in_valid falls.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

    localparam int unsigned FLAG_W = 4;
    localparam int unsigned OP_W   = 4;

    // Flag positions inside a flag nibble {N,Z,C,V}
    localparam int unsigned FL_N = 3;
    localparam int unsigned FL_Z = 2;
    localparam int unsigned FL_C = 1;
    localparam int unsigned FL_V = 0;

    typedef enum logic [OP_W-1:0] {
        OP_AND    = 4'd0,
        OP_XOR    = 4'd1,
        OP_SUB    = 4'd2,
        OP_RSUB   = 4'd3,
        OP_ADD    = 4'd4,
        OP_ADDC   = 4'd5,
        OP_SUBC   = 4'd6,
        OP_RSUBC  = 4'd7,
        OP_TEST   = 4'd8,
        OP_TESTEQ = 4'd9,
        OP_CMP    = 4'd10,
        OP_CMPN   = 4'd11,
        OP_OR     = 4'd12,
        OP_MOVE   = 4'd13,
        OP_CLR    = 4'd14,
        OP_NOT    = 4'd15
    } dp_op_e;

    function automatic logic is_compare(input dp_op_e op);
        return (op == OP_TEST) || (op == OP_TESTEQ) || (op == OP_CMP) || (op == OP_CMPN);
    endfunction

    function automatic logic is_logical(input dp_op_e op);
        case (op)
            OP_AND, OP_XOR, OP_TEST, OP_TESTEQ,
            OP_OR, OP_MOVE, OP_CLR, OP_NOT: return 1'b1;
            default:                        return 1'b0;
        endcase
    endfunction

    function automatic logic is_subtract(input dp_op_e op);
        case (op)
            OP_SUB, OP_RSUB, OP_SUBC, OP_RSUBC, OP_CMP: return 1'b1;
            default:                                    return 1'b0;
        endcase
    endfunction

    function automatic logic is_reverse(input dp_op_e op);
        return (op == OP_RSUB) || (op == OP_RSUBC);
    endfunction

    function automatic logic takes_carry(input dp_op_e op);
        return (op == OP_ADDC) || (op == OP_SUBC) || (op == OP_RSUBC);
    endfunction

endpackage

// File: rtl/dp_logic_unit.sv
module dp_logic_unit
    import dp_alu_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  dp_op_e            op,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    output logic [DATA_W-1:0] res
);

    always_comb begin
        case (op)
            OP_AND, OP_TEST:   res = a_in & b_in;
            OP_XOR, OP_TESTEQ: res = a_in ^ b_in;
            OP_OR:             res = a_in | b_in;
            OP_MOVE:           res = b_in;
            OP_CLR:            res = a_in & ~b_in;
            OP_NOT:            res = ~b_in;
            default:           res = '0;
        endcase
    end

endmodule

// File: rtl/dp_arith_unit.sv
module dp_arith_unit
    import dp_alu_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  dp_op_e            op,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              c_in,
    output logic [DATA_W-1:0] sum,
    output logic              carry,
    output logic              ovf
);

    localparam int unsigned MSB = DATA_W - 1;

    logic [DATA_W-1:0] lhs_d;
    logic [DATA_W-1:0] rhs_d;
    logic [DATA_W-1:0] rhs_eff_d;
    logic              cin_d;
    logic [DATA_W:0]   full_d;

    always_comb begin
        // Reverse forms swap the operands of the subtractor
        lhs_d     = is_reverse(op) ? b_in : a_in;
        rhs_d     = is_reverse(op) ? a_in : b_in;
        // Subtraction is lhs + ~rhs + 1; with carry, the +1 becomes +C
        rhs_eff_d = is_subtract(op) ? ~rhs_d : rhs_d;
        if (takes_carry(op)) begin
            cin_d = c_in;
        end else begin
            cin_d = is_subtract(op);
        end
        full_d = {1'b0, lhs_d} + {1'b0, rhs_eff_d} + {{DATA_W{1'b0}}, cin_d};
        sum    = full_d[DATA_W-1:0];
        // Carry out of the top bit: for subtraction it reads as "no borrow"
        carry  = full_d[DATA_W];
        ovf    = (lhs_d[MSB] == rhs_eff_d[MSB]) && (full_d[MSB] != lhs_d[MSB]);
    end

endmodule

// File: rtl/dp_flag_unit.sv
module dp_flag_unit
    import dp_alu_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  dp_op_e             op,
    input  logic               set_flags,
    input  logic               to_pc,
    input  logic [DATA_W-1:0]  res,
    input  logic               arith_c,
    input  logic               arith_v,
    input  logic               shift_c,
    input  logic [FLAG_W-1:0]  flags_in,
    output logic [FLAG_W-1:0]  flags_next,
    output logic               status_load
);

    always_comb begin
        flags_next  = flags_in;
        status_load = 1'b0;
        if (set_flags) begin
            if (to_pc) begin
                // Whole status word comes from the result, compares included
                status_load = 1'b1;
                flags_next  = res[DATA_W-1 -: FLAG_W];
            end else begin
                flags_next[FL_N] = res[DATA_W-1];
                flags_next[FL_Z] = (res == '0);
                if (is_logical(op)) begin
                    flags_next[FL_C] = shift_c;
                    flags_next[FL_V] = flags_in[FL_V];
                end else begin
                    flags_next[FL_C] = arith_c;
                    flags_next[FL_V] = arith_v;
                end
            end
        end
    end

endmodule

// File: rtl/dp_exec_alu.sv
module dp_exec_alu
    import dp_alu_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned PC_IDX = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   opcode,
    input  logic              set_flags,
    input  logic [IDX_W-1:0]  dest_idx,
    input  logic [DATA_W-1:0] op1,
    input  logic [DATA_W-1:0] op2,
    input  logic              shift_carry,
    input  logic [FLAG_W-1:0] flags_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              reg_we,
    output logic              pc_we,
    output logic              status_we,
    output logic [FLAG_W-1:0] flags_out
);

    localparam logic [IDX_W-1:0] PC_SEL = IDX_W'(PC_IDX);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] res;
        logic              rf_we;
        logic              pc_we;
        logic              st_we;
        logic [FLAG_W-1:0] flags;
    } stage_t;

    dp_op_e            op_d;
    logic              to_pc_d;
    logic [DATA_W-1:0] logic_res_d;
    logic [DATA_W-1:0] arith_res_d;
    logic              arith_c_d;
    logic              arith_v_d;
    logic [DATA_W-1:0] res_d;
    logic [FLAG_W-1:0] flags_next_d;
    logic              status_load_d;
    stage_t            stage_d;
    stage_t            stage_q;

    assign op_d    = dp_op_e'(opcode);
    assign to_pc_d = (dest_idx == PC_SEL);

    dp_logic_unit #(.DATA_W(DATA_W)) u_logic (
        .op   (op_d),
        .a_in (op1),
        .b_in (op2),
        .res  (logic_res_d)
    );

    dp_arith_unit #(.DATA_W(DATA_W)) u_arith (
        .op    (op_d),
        .a_in  (op1),
        .b_in  (op2),
        .c_in  (flags_in[FL_C]),
        .sum   (arith_res_d),
        .carry (arith_c_d),
        .ovf   (arith_v_d)
    );

    assign res_d = is_logical(op_d) ? logic_res_d : arith_res_d;

    dp_flag_unit #(.DATA_W(DATA_W)) u_flags (
        .op          (op_d),
        .set_flags   (set_flags),
        .to_pc       (to_pc_d),
        .res         (res_d),
        .arith_c     (arith_c_d),
        .arith_v     (arith_v_d),
        .shift_c     (shift_carry),
        .flags_in    (flags_in),
        .flags_next  (flags_next_d),
        .status_load (status_load_d)
    );

    always_comb begin
        stage_d       = stage_q;
        stage_d.valid = 1'b0;
        stage_d.rf_we = 1'b0;
        stage_d.pc_we = 1'b0;
        stage_d.st_we = 1'b0;
        if (in_valid) begin
            stage_d.valid = 1'b1;
            stage_d.res   = res_d;
            stage_d.rf_we = !is_compare(op_d) && !to_pc_d;
            stage_d.pc_we = !is_compare(op_d) && to_pc_d;
            stage_d.st_we = status_load_d;
            stage_d.flags = flags_next_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid = stage_q.valid;
    assign result    = stage_q.res;
    assign reg_we    = stage_q.rf_we;
    assign pc_we     = stage_q.pc_we;
    assign status_we = stage_q.st_we;
    assign flags_out = stage_q.flags;

    // Compare codes never write a register or the program counter
    p_cmp_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode[3:2] == 2'b10) |=> (!reg_we && !pc_we));

    // Flags untouched when flag setting is off
    p_keep_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !set_flags) |=> (flags_out == $past(flags_in) && !status_we));

    // Status word load from the result top nibble
    p_status_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && set_flags && dest_idx == PC_SEL) |=>
            (status_we && flags_out == result[DATA_W-1 -: FLAG_W]));

    // Logical ops take carry from the shifter and keep V
    p_logic_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && set_flags && dest_idx != PC_SEL && is_logical(dp_op_e'(opcode))) |=>
            (flags_out[FL_C] == $past(shift_carry) && flags_out[FL_V] == $past(flags_in[FL_V])));

    // Program counter strobe and register strobe are exclusive
    p_pc_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dest_idx == PC_SEL && !is_compare(dp_op_e'(opcode))) |=> (pc_we && !reg_we));

    // One-edge latency and idle cycles
    p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(in_valid)));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!reg_we && !pc_we && !status_we));

    // Reset clears valid, strobes and flags
    p_reset_clear_r10: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !reg_we && !pc_we && !status_we && flags_out == '0));

endmodule

// File: tb/test_dp_exec_alu.sv
`timescale 1ns/100ps
module test_dp_exec_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  opcode = '0;
    logic        set_flags = 1'b0;
    logic [3:0]  dest_idx = '0;
    logic [31:0] op1 = '0;
    logic [31:0] op2 = '0;
    logic        shift_carry = 1'b0;
    logic [3:0]  flags_in = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        reg_we;
    logic        pc_we;
    logic        status_we;
    logic [3:0]  flags_out;

    int total = 0;
    int bad = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] res;
        logic        rf;
        logic        pc;
        logic        st;
        logic [3:0]  fl;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    dp_exec_alu i_dp_exec_alu (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .opcode      (opcode),
        .set_flags   (set_flags),
        .dest_idx    (dest_idx),
        .op1         (op1),
        .op2         (op2),
        .shift_carry (shift_carry),
        .flags_in    (flags_in),
        .out_valid   (out_valid),
        .result      (result),
        .reg_we      (reg_we),
        .pc_we       (pc_we),
        .status_we   (status_we),
        .flags_out   (flags_out)
    );

    // Reference model of the arithmetic, written from the requirements
    function automatic exp_t model(input int op, input logic [31:0] a, input logic [31:0] b,
                                   input logic sc, input logic s, input int dst, input logic [3:0] fi);
        exp_t e;
        longint sa, sb2, sv, ua, ub, uv;
        logic c, v, logical, cmp;
        logic [31:0] r;
        sa = longint'($signed(a));
        sb2 = longint'($signed(b));
        ua = longint'({32'd0, a});
        ub = longint'({32'd0, b});
        c = 1'b0; v = 1'b0; r = '0;
        logical = (op inside {0, 1, 8, 9, 12, 13, 14, 15});
        cmp = (op inside {8, 9, 10, 11});
        case (op)
            0, 8:  r = a & b;
            1, 9:  r = a ^ b;
            12:    r = a | b;
            13:    r = b;
            14:    r = a & ~b;
            15:    r = ~b;
            4, 11: begin uv = ua + ub; sv = sa + sb2; end
            5:     begin uv = ua + ub + fi[1]; sv = sa + sb2 + fi[1]; end
            2, 10: begin uv = ua - ub; sv = sa - sb2; end
            3:     begin uv = ub - ua; sv = sb2 - sa; end
            6:     begin uv = ua - ub + fi[1] - 1; sv = sa - sb2 + fi[1] - 1; end
            7:     begin uv = ub - ua + fi[1] - 1; sv = sb2 - sa + fi[1] - 1; end
            default: ;
        endcase
        if (!logical) begin
            r = uv[31:0];
            if (op inside {4, 5, 11}) c = (uv >= 64'sh1_0000_0000);
            else                      c = (uv >= 0);
            v = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
        end
        e.res = r;
        e.rf  = !cmp && dst != 15;
        e.pc  = !cmp && dst == 15;
        e.st  = s && dst == 15;
        if (!s)            e.fl = fi;
        else if (dst == 15) e.fl = r[31:28];
        else if (logical)  e.fl = {r[31], r == 0, sc, fi[0]};
        else               e.fl = {r[31], r == 0, c, v};
        if (e.st)                  e.tag = "R7";
        else if (!s)               e.tag = "R6";
        else if (cmp)              e.tag = "R4";
        else if (dst == 15)        e.tag = "R8";
        else if (logical)          e.tag = "R5";
        else if (op inside {4, 5}) e.tag = "R2";
        else                       e.tag = "R3";
        return e;
    endfunction

    task automatic issue(input int op, input logic [31:0] a, input logic [31:0] b,
                         input logic sc, input logic s, input int dst, input logic [3:0] fi);
        @(negedge clk);
        opcode = 4'(op); op1 = a; op2 = b; shift_carry = sc;
        set_flags = s; dest_idx = 4'(dst); flags_in = fi; in_valid = 1'b1;
        sb.push_back(model(op, a, b, sc, s, dst, fi));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            opcode = 4'($urandom);
            op1 = $urandom;
        end
    endtask

    // Monitor: results are due one edge after acceptance
    always @(posedge clk) begin
        #1;
        if (mon_en && rst_n) begin
            if (out_valid) begin
                total++;
                if (sb.size() == 0) begin
                    bad++;
                    $display("FAIL R9 out_valid with nothing issued: actual=1 expected=0");
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (result !== e.res || reg_we !== e.rf || pc_we !== e.pc ||
                        status_we !== e.st || flags_out !== e.fl) begin
                        bad++;
                        $display("FAIL %s actual res=%h rf=%b pc=%b st=%b fl=%b expected res=%h rf=%b pc=%b st=%b fl=%b",
                                 e.tag, result, reg_we, pc_we, status_we, flags_out,
                                 e.res, e.rf, e.pc, e.st, e.fl);
                    end
                end
            end else begin
                total++;
                if (sb.size() != 0 || reg_we || pc_we || status_we) begin
                    bad++;
                    $display("FAIL R9 idle cycle: actual valid=0 pend=%0d strobes=%b%b%b expected pend=0 strobes=000",
                             sb.size(), reg_we, pc_we, status_we);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R10: reset state, with activity on the inputs
        in_valid = 1'b1; set_flags = 1'b1; flags_in = 4'hF; op1 = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        total++;
        if (out_valid !== 1'b0 || reg_we !== 1'b0 || pc_we !== 1'b0 ||
            status_we !== 1'b0 || flags_out !== 4'h0) begin
            bad++;
            $display("FAIL R10 reset: actual v=%b rf=%b pc=%b st=%b fl=%b expected all zero",
                     out_valid, reg_we, pc_we, status_we, flags_out);
        end
        in_valid = 1'b0;
        rst_n = 1'b1;
        mon_en = 1'b1;
        idle(2);

        // R1: logical results
        issue(0,  32'hF0F0_1234, 32'hFF00_FF00, 1'b0, 1'b0, 3, 4'h0);
        issue(1,  32'hAAAA_5555, 32'hFFFF_0000, 1'b0, 1'b0, 4, 4'h0);
        issue(12, 32'h1200_0034, 32'h0056_7800, 1'b0, 1'b0, 5, 4'h0);
        issue(13, 32'h1111_1111, 32'hCAFE_F00D, 1'b0, 1'b0, 6, 4'h0);
        issue(14, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 1'b0, 1'b0, 7, 4'h0);
        issue(15, 32'h0,         32'h0000_00FF, 1'b0, 1'b0, 8, 4'h0);
        // R5: logical with flags, zero result, shifter carry, V kept
        issue(0,  32'h0000_FFFF, 32'hFFFF_0000, 1'b1, 1'b1, 1, 4'b0001);
        issue(15, 32'h0,         32'h0000_0000, 1'b0, 1'b1, 2, 4'b0011);
        // R2: add, carry, overflow
        issue(4, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b1, 1, 4'h0);
        issue(4, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b1, 1, 4'h0);
        issue(5, 32'hFFFF_FFFE, 32'h0000_0001, 1'b0, 1'b1, 1, 4'b0010);
        issue(5, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1, 1, 4'b0000);
        // R3: subtract forms, borrow and no borrow
        issue(2, 32'h0000_0000, 32'h0000_0001, 1'b0, 1'b1, 1, 4'h0);
        issue(2, 32'h0000_0005, 32'h0000_0005, 1'b0, 1'b1, 1, 4'h0);
        issue(3, 32'h0000_0003, 32'h0000_0010, 1'b0, 1'b1, 1, 4'h0);
        issue(6, 32'h0000_0010, 32'h0000_0003, 1'b0, 1'b1, 1, 4'b0000);
        issue(6, 32'h8000_0000, 32'h0000_0001, 1'b0, 1'b1, 1, 4'b0010);
        issue(7, 32'h0000_0002, 32'h0000_0002, 1'b0, 1'b1, 1, 4'b0000);
        issue(7, 32'h0000_0001, 32'h8000_0000, 1'b0, 1'b1, 1, 4'b0010);
        // R4: compares
        issue(10, 32'h0000_0004, 32'h0000_0009, 1'b0, 1'b1, 0, 4'h0);
        issue(11, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b1, 0, 4'h0);
        issue(8,  32'h0000_00F0, 32'h0000_000F, 1'b1, 1'b1, 0, 4'h0);
        issue(9,  32'h1234_5678, 32'h1234_5678, 1'b0, 1'b1, 0, 4'h1);
        // R7: status load, compare and non-compare
        issue(10, 32'hA000_0000, 32'h0000_0000, 1'b0, 1'b1, 15, 4'h0);
        issue(13, 32'h0,         32'h5000_0004, 1'b0, 1'b1, 15, 4'hF);
        // R8: program counter write without flags, compare to 15 without flags
        issue(4, 32'h0000_1000, 32'h0000_0008, 1'b0, 1'b0, 15, 4'h6);
        issue(9, 32'hFFFF_0000, 32'h0000_FFFF, 1'b0, 1'b0, 15, 4'h9);
        // R6: flags held with set_flags low on an overflowing add
        issue(4, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, 1'b0, 2, 4'b1010);
        // R9: gap then back-to-back
        idle(3);

        for (int i = 0; i < 400; i++) begin
            int dst;
            logic [31:0] a, b;
            dst = ($urandom % 4 == 0) ? 15 : int'($urandom % 15);
            a = ($urandom % 5 == 0) ? 32'h8000_0000 : $urandom;
            b = ($urandom % 5 == 0) ? a : $urandom;
            issue(int'($urandom % 16), a, b, 1'($urandom), 1'($urandom), dst, 4'($urandom));
            if ($urandom % 7 == 0) idle(1);
        end
        idle(4);

        total++;
        if (sb.size() != 0) begin
            bad++;
            $display("FAIL R9 results missing: actual pending=%0d expected=0", sb.size());
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule